// File: doc/BRIEF.md
# Special-Modulus Chunk Folding Reducer

This block computes the residue of a wide unsigned dividend for one of two moduli of special form, M = 2^N - 1 or M = 2^N + 1. A mode bit given with each dividend selects the modulus. No divider is used. The dividend is cut into N-bit chunks, and the chunks are combined into a signed accumulator, one chunk per clock.

- For 2^N - 1, every chunk is added.
- For 2^N + 1, chunks with even index are added and chunks with odd index are subtracted.

The partial result can still be wider than N bits after the first pass. It is therefore folded again, one step per clock. Each step splits the accumulator into a high part and the low N bits and recombines them with the same sign rule. Folding stops once the value lies in [-2^N, 2^N). A correction stage then brings the value into [0, M): it adds M while the value is negative and subtracts M while the value is at least M.

A dividend is handed over with a valid/ready handshake. The block works on one dividend at a time. The residue appears together with a one-cycle result strobe.

Top module: `mfred_top`

## Requirements
- R1: During and straight after reset, in_ready is 1 and out_valid is 0.
- R2: A dividend is taken only in a cycle where in_valid and in_ready are both 1. in_ready stays 0 from the cycle after acceptance until the cycle in which out_valid is 1, and in that cycle in_ready is 1 again.
- R3: out_valid is 1 for exactly one cycle per accepted dividend.
- R4: With in_mode = 0, out_residue equals dividend mod (2^N - 1) and is always less than 2^N - 1.
- R5: With in_mode = 0, a dividend that is a nonzero multiple of 2^N - 1 (for example a single all-ones chunk) gives out_residue 0, never 2^N - 1.
- R6: With in_mode = 1, out_residue equals dividend mod (2^N + 1). It is at most 2^N, and the value 2^N is reported on the extra top bit of out_residue.
- R7: With in_mode = 1, a dividend whose alternating chunk sum is negative (chunk 0 added, chunk 1 subtracted, chunk 2 added, and so on) still gives the correct non-negative residue. The correction stage only ever sees values in [-2^N, 2^N].
- R8: The signed accumulator, N + ceil(log2(chunk count)) + 2 bits wide, never overflows in any fold step, including for the all-ones dividend.
- R9: A zero dividend gives 0 in both modes. The all-ones dividend gives its true residue in both modes.
- R10: in_valid, in_dividend and in_mode are ignored while in_ready is 0. Data offered during that time does not change the residue being computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Dividend offered |
| in_ready | output | 1 | Block can take a dividend |
| in_dividend | input | DIV_W | Unsigned dividend |
| in_mode | input | 1 | 0: modulus 2^N-1, 1: modulus 2^N+1 |
| out_valid | output | 1 | One-cycle strobe marking a residue |
| out_residue | output | CHUNK_W+1 | Residue in [0, M) |

## Verification
The assertions check on every cycle:
- the residue is within range for its mode, including that 2^N - 1 is never reported for the 2^N - 1 modulus;
- the result strobe lasts one cycle;
- in_ready drops after acceptance;
- no fold step overflows the accumulator;
- the correction stage receives only values inside its narrow window.

Whether each residue is arithmetically right can only be shown by the bench scenarios. These are an exhaustive sweep of every 12-bit dividend in both modes with 4-bit chunks, plus transfers with conflicting data held on the input while the block is busy.

// File: rtl/mfred_pkg.sv
package mfred_pkg;
  typedef enum logic {
    MODE_MERS = 1'b0,
    MODE_FERM = 1'b1
  } fold_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FOLD   = 3'd1,
    ST_REFOLD = 3'd2,
    ST_FIX    = 3'd3,
    ST_DONE   = 3'd4
  } fsm_e;
endpackage

// File: rtl/mfred_fold_step.sv
module mfred_fold_step #(
  parameter int CHUNK_W = 13,
  parameter int ACC_W   = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chk_en,
  input  logic signed [ACC_W-1:0] base,
  input  logic [CHUNK_W-1:0]      opnd,
  input  logic                    sub,
  output logic signed [ACC_W-1:0] result
);
  localparam int EXT_W = ACC_W + 1;

  logic signed [EXT_W-1:0] base_x;
  logic signed [EXT_W-1:0] opnd_x;
  logic signed [EXT_W-1:0] wide_sum;

  always_comb begin
    base_x   = {base[ACC_W-1], base};
    opnd_x   = {{(EXT_W-CHUNK_W){1'b0}}, opnd};
    wide_sum = sub ? (base_x - opnd_x) : (base_x + opnd_x);
    result   = wide_sum[ACC_W-1:0];
  end

  // R8: the extra guard bit must agree with the accumulator sign bit
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (wide_sum[EXT_W-1] == wide_sum[ACC_W-1]));
endmodule

// File: rtl/mfred_correct.sv
module mfred_correct
  import mfred_pkg::*;
#(
  parameter int CHUNK_W = 13,
  parameter int ACC_W   = 19
) (
  input  logic signed [ACC_W-1:0] acc,
  input  fold_mode_e              mode,
  output logic signed [ACC_W-1:0] acc_next,
  output logic                    in_range
);
  localparam logic signed [ACC_W-1:0] MERS_M = (ACC_W'(1) << CHUNK_W) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] FERM_M = (ACC_W'(1) << CHUNK_W) + ACC_W'(1);

  logic signed [ACC_W-1:0] modulus;
  logic                    is_neg;
  logic                    too_big;

  always_comb begin
    modulus  = (mode == MODE_FERM) ? FERM_M : MERS_M;
    is_neg   = acc[ACC_W-1];
    too_big  = !is_neg && (acc >= modulus);
    in_range = !is_neg && !too_big;
    if (is_neg)       acc_next = acc + modulus;
    else if (too_big) acc_next = acc - modulus;
    else              acc_next = acc;
  end
endmodule

// File: rtl/mfred_top.sv
module mfred_top
  import mfred_pkg::*;
#(
  parameter int CHUNK_W = 13,
  parameter int DIV_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIV_W-1:0]   in_dividend,
  input  logic               in_mode,
  output logic               out_valid,
  output logic [CHUNK_W:0]   out_residue
);
  localparam int CHUNKS = (DIV_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W  = CHUNKS * CHUNK_W;
  localparam int ACC_W  = CHUNK_W + $clog2(CHUNKS) + 2;
  localparam int CNT_W  = $clog2(CHUNKS + 1);
  localparam logic signed [ACC_W-1:0] SPAN = ACC_W'(1) << CHUNK_W;
  localparam logic [CHUNK_W:0] MERS_TOP = {1'b0, {CHUNK_W{1'b1}}};
  localparam logic [CHUNK_W:0] FERM_TOP = {1'b1, {CHUNK_W{1'b0}}};

  fsm_e                    state_q, state_d;
  logic [PAD_W-1:0]        shreg_q, shreg_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    par_q, par_d;
  fold_mode_e              mode_q, mode_d;
  logic [CHUNK_W:0]        res_q, res_d;
  logic                    work_en, res_en;

  logic                    accept;
  logic signed [ACC_W-1:0] hi_part;
  logic [CHUNK_W-1:0]      lo_part;
  logic                    folded;
  logic signed [ACC_W-1:0] step_base;
  logic [CHUNK_W-1:0]      step_opnd;
  logic                    step_sub;
  logic                    step_chk;
  logic signed [ACC_W-1:0] step_out;
  logic signed [ACC_W-1:0] fix_out;
  logic                    fix_ok;

  assign in_ready    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign out_valid   = (state_q == ST_DONE);
  assign out_residue = res_q;
  assign accept      = in_valid && in_ready;

  assign hi_part = acc_q >>> CHUNK_W;
  assign lo_part = acc_q[CHUNK_W-1:0];
  assign folded  = (hi_part == '0) || (hi_part == {ACC_W{1'b1}});

  always_comb begin
    if (state_q == ST_REFOLD) begin
      step_base = (mode_q == MODE_FERM) ? -hi_part : hi_part;
      step_opnd = lo_part;
      step_sub  = 1'b0;
    end else begin
      step_base = acc_q;
      step_opnd = shreg_q[CHUNK_W-1:0];
      step_sub  = (mode_q == MODE_FERM) && par_q;
    end
  end

  assign step_chk = (state_q == ST_FOLD) || ((state_q == ST_REFOLD) && !folded);

  mfred_fold_step #(.CHUNK_W(CHUNK_W), .ACC_W(ACC_W)) fold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (step_chk),
    .base   (step_base),
    .opnd   (step_opnd),
    .sub    (step_sub),
    .result (step_out)
  );

  mfred_correct #(.CHUNK_W(CHUNK_W), .ACC_W(ACC_W)) corr_i (
    .acc      (acc_q),
    .mode     (mode_q),
    .acc_next (fix_out),
    .in_range (fix_ok)
  );

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    par_d   = par_q;
    mode_d  = mode_q;
    res_d   = res_q;
    work_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        work_en = 1'b1;
        if (accept) begin
          shreg_d = PAD_W'(in_dividend);
          acc_d   = '0;
          cnt_d   = CNT_W'(CHUNKS);
          par_d   = 1'b0;
          mode_d  = fold_mode_e'(in_mode);
          state_d = ST_FOLD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FOLD: begin
        work_en = 1'b1;
        acc_d   = step_out;
        shreg_d = shreg_q >> CHUNK_W;
        par_d   = !par_q;
        cnt_d   = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_REFOLD;
      end
      ST_REFOLD: begin
        work_en = 1'b1;
        if (folded) state_d = ST_FIX;
        else        acc_d   = step_out;
      end
      ST_FIX: begin
        work_en = 1'b1;
        if (fix_ok) begin
          res_en  = 1'b1;
          res_d   = acc_q[CHUNK_W:0];
          state_d = ST_DONE;
        end else begin
          acc_d = fix_out;
        end
      end
      default: begin
        work_en = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      par_q   <= 1'b0;
      mode_q  <= MODE_MERS;
    end else if (work_en) begin
      shreg_q <= shreg_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      par_q   <= par_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4 and R5: residue below 2^N - 1, so 2^N - 1 itself is never reported
  assert_mers_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mode_q == MODE_MERS)) |-> (out_residue < MERS_TOP));

  assert_ferm_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mode_q == MODE_FERM)) |-> (out_residue <= FERM_TOP));

  assert_fix_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) |-> ((acc_q >= -SPAN) && (acc_q <= SPAN)));
endmodule

// File: tb/mfred_top_tb_top.sv
module mfred_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int DW         = 12;
  localparam int MERS       = (1 << N) - 1;
  localparam int FERM       = (1 << N) + 1;
  localparam int WATCHDOG   = 190000;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_dividend;
  logic          in_mode;
  logic          out_valid;
  logic [N:0]    out_residue;

  int checks = 0;
  int fails  = 0;

  mfred_top #(.CHUNK_W(N), .DIV_W(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dividend (in_dividend),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_residue (out_residue)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xact(input int d, input bit m, input bit junk, output int res);
    int n;
    @(negedge clk);
    n = 0;
    while (!in_ready && n < 64) begin
      @(negedge clk);
      n++;
    end
    in_valid    = 1'b1;
    in_dividend = DW'(d);
    in_mode     = m;
    @(negedge clk);
    check("R2 ready low after accept", int'(in_ready), 0);
    if (junk) begin
      in_dividend = ~DW'(d);
      in_mode     = !m;
      @(negedge clk);
    end
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    check("R3 result strobe seen", int'(out_valid), 1);
    check("R2 ready high with result", int'(in_ready), 1);
    res = int'(out_residue);
    @(negedge clk);
    check("R3 strobe lasts one cycle", int'(out_valid), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d cycles", WATCHDOG, WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int res;
    int exp;
    int alt;
    string tag;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_dividend = '0;
    in_mode     = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(in_ready), 1);
    check("R1 no strobe in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    check("R1 no strobe after reset", int'(out_valid), 0);

    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < (1 << DW); d++) begin
        xact(d, m[0], 1'b0, res);
        exp = (m == 1) ? (d % FERM) : (d % MERS);
        alt = (d & 15) - ((d >> 4) & 15) + ((d >> 8) & 15);
        if (d == 0 || d == (1 << DW) - 1) tag = "R9 zero or all-ones dividend";
        else if (m == 0 && exp == 0)      tag = "R5 multiple of 2^N-1 gives 0";
        else if (m == 0)                  tag = "R4 residue mod 2^N-1";
        else if (alt < 0)                 tag = "R7 negative alternating sum";
        else                              tag = "R6 residue mod 2^N+1";
        check(tag, res, exp);
      end
    end

    xact((1 << DW) - 1, 1'b0, 1'b0, res);
    check("R8 widest chunk sum, mode 0", res, ((1 << DW) - 1) % MERS);
    xact(12'h0F0, 1'b1, 1'b0, res);
    check("R8 largest negative fold, mode 1", res, 12'h0F0 % FERM);

    xact(12'h5A3, 1'b0, 1'b1, res);
    check("R10 busy input ignored, mode 0", res, 12'h5A3 % MERS);
    xact(12'h3C7, 1'b1, 1'b1, res);
    check("R10 busy input ignored, mode 1", res, 12'h3C7 % FERM);
    xact(12'h010, 1'b1, 1'b1, res);
    check("R10 busy input ignored, residue 2^N", res, 12'h010 % FERM);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule